// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualization capability registers of a PCI Express physical function. A configuration agent reaches it through a plain dword-addressed read/write port carrying byte enables. Reads are combinational on the address. Writes take effect on the next rising clock edge. The block answers only inside a sixteen-dword window that starts at a base address set by a parameter. It drives the virtual-function enable, the virtual-function memory enable, the ARI-hierarchy flag, the number of live virtual functions, and the six virtual-function BAR words to the rest of the function.

The write masks are not fixed. While virtual functions are enabled, the virtual-function count is frozen. The enable bit can only be raised while the programmed count is no larger than the total the function offers. The identity fields come from parameters and are read-only: total and initial counts, routing offset, stride, device ID and supported page sizes. The system page size accepts only supported page bits. Each BAR accepts only the address bits above its size. A 64-bit memory BAR uses the following dword as its upper half. A function-level reset pulse restores the register state, the same as the main reset.

Top module: `sriov_cap_regfile`

## Requirements
- R1: After reset, window dword 2 (control) reads 0, dword 4 (count) reads 0, dword 8 (system page size) reads 0x00000001, and each BAR dword 9..14 reads its type code. The upper half of a 64-bit BAR reads 0. With the defaults the BARs read 0x4, 0, 0, 0x1, 0, 0.
- R2: In dword 2, only bit 0 (VF enable), bit 3 (memory enable) and bit 4 (ARI hierarchy) can be written. Every other bit of dword 2 reads 0.
- R3: Dword 4 bits 15:0 hold the VF count. All 16 bits are writable while VF enable is 0. No bit is writable while VF enable is 1.
- R4: A write can set VF enable only while the stored count is at most TOTAL_VFS. A write can clear VF enable whenever it is 1. Memory enable and ARI are always writable.
- R5: Dword 8 accepts only the supported page bits, which are 0x553 OR'd with OPT_PGSIZE (0x557 by default).
- R6: The following fields are read-only and come from parameters:
  - dword 3 holds {TOTAL_VFS, INITIAL_VFS};
  - dword 5 holds {VF_STRIDE, VF_OFFSET};
  - dword 6 holds VF_DEVICE_ID in bits 31:16;
  - dword 7 holds the supported page sizes.
- R7: A func_rst pulse has the same effect as reset, and takes priority over a write in the same cycle.
- R8: A BAR with size 2^S takes only bits S and up, and keeps its type bits. A 64-bit memory BAR (type bit0=0, bits2:1=10) makes the next dword its writable upper half. A BAR with S=0 is read-only. With the defaults the all-ones write results are 0xFFFFC004, 0xFFFFFFFF, 0xFFFFF000, 0xFFFFFF01, 0 and 0.
- R9: vf_active_count equals the count while VF enable is 1, and 0 while it is 0.
- R10: Byte lane k of cfg_be gates data bits 8k+7..8k, combined with the write mask.
- R11: A write outside the window changes nothing. A read outside the window reads 0. Dwords 0, 1 and 15 read 0.
- R12: vf_enable, vf_mem_enable, vf_ari_hier and vf_bar_flat (BAR i in bits 32i+31..32i) follow the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| func_rst | input | 1 | Synchronous function-level reset pulse |
| cfg_addr | input | ADDR_W | Dword configuration address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| vf_enable | output | 1 | VF enable bit |
| vf_mem_enable | output | 1 | VF memory space enable bit |
| vf_ari_hier | output | 1 | ARI hierarchy bit |
| vf_active_count | output | 16 | Number of live VFs |
| vf_bar_flat | output | 6*32 | All six VF BAR words |

## Verification
The assertions assume three things about the inputs. First, func_rst and cfg_wr are clean single-cycle-or-longer levels. Second, the count dword and the control dword are never written in the same cycle, which the single-address port already guarantees. Third, the BAR parameters mark at most one dword as the upper half of each 64-bit BAR. The stimulus drives one access per cycle on the falling edge, using legal byte-enable patterns only. It includes counts above TOTAL_VFS so that the enable gate is exercised, and it keeps the default BAR layout so that pairing stays consistent.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;
  localparam int NUM_BARS = 6;
  localparam int WIN_DW   = 16;

  localparam logic [3:0] DW_CTRL  = 4'd2;
  localparam logic [3:0] DW_VFCNT = 4'd3;
  localparam logic [3:0] DW_NUMVF = 4'd4;
  localparam logic [3:0] DW_RID   = 4'd5;
  localparam logic [3:0] DW_DID   = 4'd6;
  localparam logic [3:0] DW_SUPPG = 4'd7;
  localparam logic [3:0] DW_SYSPG = 4'd8;
  localparam logic [3:0] DW_BAR0  = 4'd9;

  localparam int CB_VFE = 0;
  localparam int CB_MSE = 3;
  localparam int CB_ARI = 4;

  localparam logic [15:0] PG_MINREQ = 16'h0553;

  // byte-lane gated masked update
  function automatic logic [31:0] merge_be(input logic [31:0] old, input logic [31:0] wdat,
                                           input logic [31:0] mask, input logic [3:0] be);
    logic [31:0] lane;
    for (int b = 0; b < 4; b++) lane[b*8 +: 8] = {8{be[b]}};
    return (old & ~(mask & lane)) | (wdat & mask & lane);
  endfunction

  // control write mask: enable bit writable if already set or count fits
  function automatic logic [15:0] ctrl_wmask(input logic vfe, input logic [15:0] num,
                                             input logic [15:0] total);
    logic [15:0] m;
    m = '0;
    m[CB_MSE] = 1'b1;
    m[CB_ARI] = 1'b1;
    m[CB_VFE] = vfe || (num <= total);
    return m;
  endfunction

  function automatic logic is_mem64(input logic [7:0] t);
    return (t[0] == 1'b0) && (t[2:1] == 2'b10);
  endfunction

  function automatic logic bar_is_upper(input logic [NUM_BARS*8-1:0] types, input int idx);
    if (idx == 0) return 1'b0;
    return is_mem64(types[(idx-1)*8 +: 8]);
  endfunction

  function automatic logic [63:0] size_mask(input logic [5:0] szl2);
    if (szl2 == 6'd0) return 64'd0;
    return ~((64'd1 << szl2) - 64'd1);
  endfunction

  function automatic logic [31:0] bar_wmask(input logic [NUM_BARS*8-1:0] types,
                                            input logic [NUM_BARS*6-1:0] szl2, input int idx);
    logic [63:0] m;
    if (bar_is_upper(types, idx)) begin
      m = size_mask(szl2[(idx-1)*6 +: 6]);
      return m[63:32];
    end
    m = size_mask(szl2[idx*6 +: 6]);
    return m[31:0];
  endfunction

  function automatic logic [31:0] bar_reset(input logic [NUM_BARS*8-1:0] types, input int idx);
    if (bar_is_upper(types, idx)) return 32'd0;
    return {24'd0, types[idx*8 +: 8]};
  endfunction
endpackage

// File: rtl/sriov_ctrl_regs.sv
module sriov_ctrl_regs
  import sriov_cap_pkg::*;
#(
  parameter int unsigned TOTAL_VFS  = 8,
  parameter logic [15:0] OPT_PGSIZE = 16'h0004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        func_rst,
  input  logic        wr_en,
  input  logic [3:0]  wr_dw,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [15:0] ctrl_q,
  output logic [15:0] numvf_q,
  output logic [31:0] syspg_q
);
  localparam logic [15:0] TOTAL16  = 16'(TOTAL_VFS);
  localparam logic [31:0] SYS_WM   = {16'd0, PG_MINREQ | OPT_PGSIZE};
  localparam logic [31:0] SYS_RST  = 32'd1;

  logic        vfe_now;
  logic [15:0] ctrl_wm;
  logic [15:0] numvf_wm;
  logic [31:0] ctrl_new;
  logic [31:0] numvf_new;

  assign vfe_now  = ctrl_q[CB_VFE];
  assign ctrl_wm  = ctrl_wmask(vfe_now, numvf_q, TOTAL16);
  assign numvf_wm = vfe_now ? 16'h0000 : 16'hFFFF;
  assign ctrl_new  = merge_be({16'd0, ctrl_q}, wr_data, {16'd0, ctrl_wm}, wr_be);
  assign numvf_new = merge_be({16'd0, numvf_q}, wr_data, {16'd0, numvf_wm}, wr_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      numvf_q <= '0;
      syspg_q <= SYS_RST;
    end else if (func_rst) begin
      ctrl_q  <= '0;
      numvf_q <= '0;
      syspg_q <= SYS_RST;
    end else if (wr_en) begin
      case (wr_dw)
        DW_CTRL:  ctrl_q  <= ctrl_new[15:0];
        DW_NUMVF: numvf_q <= numvf_new[15:0];
        DW_SYSPG: syspg_q <= merge_be(syspg_q, wr_data, SYS_WM, wr_be);
        default: ;
      endcase
    end
  end

  assert_ctrl_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & ~16'h0019) == 16'h0000);
  assert_num_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vfe_now) && vfe_now) |-> $stable(numvf_q));
  assert_vfe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vfe_now) |-> (numvf_q <= TOTAL16));
  assert_syspg_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (syspg_q & ~SYS_WM) == 32'd0);
  assert_func_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |=> (ctrl_q == 16'd0 && numvf_q == 16'd0 && syspg_q == SYS_RST));
endmodule

// File: rtl/sriov_vf_bar_bank.sv
module sriov_vf_bar_bank
  import sriov_cap_pkg::*;
#(
  parameter logic [NUM_BARS*8-1:0] BAR_TYPES = 48'h00_00_01_00_00_04,
  parameter logic [NUM_BARS*6-1:0] BAR_SZL2  = {6'd0, 6'd0, 6'd8, 6'd12, 6'd0, 6'd14}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     func_rst,
  input  logic                     wr_en,
  input  logic [3:0]               wr_dw,
  input  logic [3:0]               wr_be,
  input  logic [31:0]              wr_data,
  output logic [NUM_BARS*32-1:0]   bars
);
  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic [31:0] WMASK = bar_wmask(BAR_TYPES, BAR_SZL2, i);
    localparam logic [31:0] RSTV  = bar_reset(BAR_TYPES, i);
    localparam logic [3:0]  MYDW  = DW_BAR0 + 4'(i);

    logic [31:0] bar_q;
    logic        bar_hit;

    assign bar_hit = wr_en && (wr_dw == MYDW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bar_q <= RSTV;
      else if (func_rst) bar_q <= RSTV;
      else if (bar_hit)  bar_q <= merge_be(bar_q, wr_data, WMASK, wr_be);
    end

    assign bars[i*32 +: 32] = bar_q;

    assert_bar_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_q & ~WMASK) == (RSTV & ~WMASK));
  end
endmodule

// File: rtl/sriov_cap_regfile.sv
module sriov_cap_regfile
  import sriov_cap_pkg::*;
#(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned CAP_BASE_DW  = 'h50,
  parameter int unsigned TOTAL_VFS    = 8,
  parameter int unsigned INITIAL_VFS  = 8,
  parameter logic [15:0] VF_OFFSET    = 16'h0001,
  parameter logic [15:0] VF_STRIDE    = 16'h0001,
  parameter logic [15:0] VF_DEVICE_ID = 16'h7A31,
  parameter logic [15:0] OPT_PGSIZE   = 16'h0004,
  parameter logic [NUM_BARS*8-1:0] BAR_TYPES = 48'h00_00_01_00_00_04,
  parameter logic [NUM_BARS*6-1:0] BAR_SZL2  = {6'd0, 6'd0, 6'd8, 6'd12, 6'd0, 6'd14}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   func_rst,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic                   cfg_wr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic                   vf_enable,
  output logic                   vf_mem_enable,
  output logic                   vf_ari_hier,
  output logic [15:0]            vf_active_count,
  output logic [NUM_BARS*32-1:0] vf_bar_flat
);
  localparam logic [ADDR_W:0] BASE_X = (ADDR_W+1)'(CAP_BASE_DW);
  localparam logic [15:0]     SUP_PG = PG_MINREQ | OPT_PGSIZE;

  logic [ADDR_W:0] rel_addr;
  logic            in_win;
  logic [3:0]      win_dw;
  logic            wr_hit;
  logic [15:0]     ctrl_q;
  logic [15:0]     numvf_q;
  logic [31:0]     syspg_q;

  assign rel_addr = {1'b0, cfg_addr} - BASE_X;
  assign in_win   = (rel_addr < (ADDR_W+1)'(WIN_DW));
  assign win_dw   = rel_addr[3:0];
  assign wr_hit   = cfg_wr && in_win;

  sriov_ctrl_regs #(.TOTAL_VFS(TOTAL_VFS), .OPT_PGSIZE(OPT_PGSIZE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .func_rst(func_rst), .wr_en(wr_hit), .wr_dw(win_dw),
    .wr_be(cfg_be), .wr_data(cfg_wdata), .ctrl_q(ctrl_q), .numvf_q(numvf_q),
    .syspg_q(syspg_q));

  sriov_vf_bar_bank #(.BAR_TYPES(BAR_TYPES), .BAR_SZL2(BAR_SZL2)) u_bars (
    .clk(clk), .rst_n(rst_n), .func_rst(func_rst), .wr_en(wr_hit), .wr_dw(win_dw),
    .wr_be(cfg_be), .wr_data(cfg_wdata), .bars(vf_bar_flat));

  always_comb begin
    cfg_rdata = '0;
    if (in_win) begin
      case (win_dw)
        DW_CTRL:  cfg_rdata = {16'd0, ctrl_q};
        DW_VFCNT: cfg_rdata = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
        DW_NUMVF: cfg_rdata = {16'd0, numvf_q};
        DW_RID:   cfg_rdata = {VF_STRIDE, VF_OFFSET};
        DW_DID:   cfg_rdata = {VF_DEVICE_ID, 16'd0};
        DW_SUPPG: cfg_rdata = {16'd0, SUP_PG};
        DW_SYSPG: cfg_rdata = syspg_q;
        default: begin
          for (int i = 0; i < NUM_BARS; i++)
            if (win_dw == DW_BAR0 + 4'(i)) cfg_rdata = vf_bar_flat[i*32 +: 32];
        end
      endcase
    end
  end

  assign vf_enable       = ctrl_q[CB_VFE];
  assign vf_mem_enable   = ctrl_q[CB_MSE];
  assign vf_ari_hier     = ctrl_q[CB_ARI];
  assign vf_active_count = vf_enable ? numvf_q : 16'd0;

  assert_outside_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> cfg_rdata == 32'd0);
  assert_count_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_active_count != 16'd0) |-> vf_enable);
  assert_outside_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !in_win && !func_rst) |=> ($stable(ctrl_q) && $stable(numvf_q) && $stable(vf_bar_flat)));
endmodule

// File: tb/sriov_cap_regfile_test.sv
module sriov_cap_regfile_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         func_rst = 1'b0;
  logic [9:0]   cfg_addr = '0;
  logic         cfg_wr = 1'b0;
  logic [3:0]   cfg_be = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         vf_enable, vf_mem_enable, vf_ari_hier;
  logic [15:0]  vf_active_count;
  logic [191:0] vf_bar_flat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam int BASE = 'h50;

  // reference state
  int unsigned m_ctrl, m_num, m_sys;
  int unsigned m_bar [6];
  int unsigned bar_wm [6] = '{32'hFFFFC000, 32'hFFFFFFFF, 32'hFFFFF000, 32'hFFFFFF00, 0, 0};
  int unsigned bar_rv [6] = '{32'h4, 0, 0, 32'h1, 0, 0};

  always #5 clk = ~clk;

  sriov_cap_regfile uut (
    .clk(clk), .rst_n(rst_n), .func_rst(func_rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vf_enable(vf_enable),
    .vf_mem_enable(vf_mem_enable), .vf_ari_hier(vf_ari_hier),
    .vf_active_count(vf_active_count), .vf_bar_flat(vf_bar_flat));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 0; m_num = 0; m_sys = 1;
    for (int i = 0; i < 6; i++) m_bar[i] = bar_rv[i];
  endtask

  function automatic int unsigned upd(int unsigned old, int unsigned d, int unsigned msk,
                                      logic [3:0] be);
    int unsigned r = old;
    for (int b = 0; b < 4; b++)
      if (be[b])
        for (int k = b*8; k < b*8+8; k++)
          if (msk[k]) r[k] = d[k];
    return r;
  endfunction

  function automatic int unsigned exp_read(int a);
    int o = a - BASE;
    if (o < 0 || o > 15) return 0;
    case (o)
      2: return m_ctrl;
      3: return 32'h0008_0008;
      4: return m_num;
      5: return 32'h0001_0001;
      6: return 32'h7A31_0000;
      7: return 32'h557;
      8: return m_sys;
      9, 10, 11, 12, 13, 14: return m_bar[o-9];
      default: return 0;
    endcase
  endfunction

  task automatic compare(input string req);
    bit en = m_ctrl[0];
    chk(vf_enable == en && vf_mem_enable == m_ctrl[3] && vf_ari_hier == m_ctrl[4],
        "R12 ctrl outs", {vf_ari_hier, vf_mem_enable, vf_enable}, {m_ctrl[4], m_ctrl[3], en});
    chk(vf_active_count == (en ? m_num : 0), "R9 active count", vf_active_count,
        en ? m_num : 0);
    for (int i = 0; i < 6; i++)
      chk(vf_bar_flat[i*32 +: 32] == m_bar[i], "R8 bar out", vf_bar_flat[i*32 +: 32], m_bar[i]);
    chk(cfg_rdata == exp_read(int'(cfg_addr)), req, cfg_rdata, exp_read(int'(cfg_addr)));
  endtask

  // one access per cycle; model updated at the edge, compared 1 ns later
  task automatic step(input int a, input bit wr, input logic [3:0] be, input int unsigned d,
                      input bit fr, input string req);
    @(negedge clk);
    cfg_addr = 10'(a); cfg_wr = wr; cfg_be = be; cfg_wdata = d; func_rst = fr;
    @(posedge clk);
    if (fr) model_reset();
    else if (wr && a >= BASE && a < BASE + 16) begin
      int o = a - BASE;
      if (o == 2) begin
        int unsigned cm = 32'h18;
        if (m_ctrl[0] || m_num <= 8) cm |= 1;
        m_ctrl = upd(m_ctrl, d, cm, be);
      end else if (o == 4) m_num = upd(m_num, d, m_ctrl[0] ? 0 : 32'hFFFF, be);
      else if (o == 8) m_sys = upd(m_sys, d, 32'h557, be);
      else if (o >= 9 && o <= 14) m_bar[o-9] = upd(m_bar[o-9], d, bar_wm[o-9], be);
    end
    #1;
    compare(req);
    @(negedge clk);
    cfg_wr = 0; func_rst = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr = 32'h1234_5678;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state, R6 read-only fields, R11 empty dwords
    for (int a = BASE - 2; a < BASE + 18; a++)
      step(a, 0, 4'h0, 0, 0, (a < BASE + 9) ? "R1 R6 reset read" : "R1 bar reset read");
    // R2 control writable bits
    step(BASE + 2, 1, 4'hF, 32'hFFFF_FFFF, 0, "R2 ctrl mask");
    // R3 count locked while enabled
    step(BASE + 4, 1, 4'hF, 32'h0000_0005, 0, "R3 count locked");
    step(BASE + 2, 1, 4'hF, 32'h0, 0, "R4 clear enable");
    step(BASE + 4, 1, 4'hF, 32'h0000_0009, 0, "R3 count writable");
    // R4 enable refused with count above total, MSE still taken
    step(BASE + 2, 1, 4'hF, 32'h0000_0009, 0, "R4 enable gated");
    step(BASE + 4, 1, 4'hF, 32'h0000_0008, 0, "R3 count to total");
    step(BASE + 2, 1, 4'hF, 32'h0000_0001, 0, "R4 enable at total");
    step(BASE + 4, 0, 4'h0, 0, 0, "R9 count read");
    step(BASE + 2, 1, 4'hF, 32'h0, 0, "R4 disable");
    // R10 byte enables
    step(BASE + 4, 1, 4'h1, 32'h0000_ABCD, 0, "R10 low byte");
    step(BASE + 4, 1, 4'h2, 32'h0000_1200, 0, "R10 high byte");
    // R5 system page size mask
    step(BASE + 8, 1, 4'hF, 32'hFFFF_FFFF, 0, "R5 syspg mask");
    // R8 BAR masks
    for (int i = 0; i < 6; i++) step(BASE + 9 + i, 1, 4'hF, 32'hFFFF_FFFF, 0, "R8 bar write");
    // R11 writes outside the window, including aliases of the control dword
    step(BASE - 14, 1, 4'hF, 32'hFFFF_FFFF, 0, "R11 outside write");
    step(BASE + 18, 1, 4'hF, 32'hFFFF_FFFF, 0, "R11 outside write");
    step(BASE + 2, 0, 4'h0, 0, 0, "R11 ctrl unchanged");
    step(BASE + 15, 1, 4'hF, 32'hFFFF_FFFF, 0, "R11 spare dword");
    // R7 function reset, with a write in the same cycle
    step(BASE + 2, 1, 4'hF, 32'h19, 1, "R7 reset beats write");
    for (int a = BASE; a < BASE + 16; a++) step(a, 0, 4'h0, 0, 0, "R7 state restored");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      int a;
      int unsigned d;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = BASE - 1 + int'(lfsr % 18);
      if (lfsr[20]) a = BASE + 2;
      else if (lfsr[21]) a = BASE + 4;
      d = {lfsr[15:0], lfsr[31:16]};
      if (a == BASE + 4) d = lfsr[9] ? 32'(lfsr[27:24]) : d;
      step(a, lfsr[22], lfsr[26:23], d, (lfsr[31:27] == 5'd3), "R6 R10 mixed read");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule